// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target (slave) side of an I2C bus, run from the system clock and controlled through a small byte-wide register port. It samples the open-drain SCL and SDA lines through synchronisers and finds START and STOP conditions. It shifts in the address byte and compares its upper seven bits with a programmed own address. On a match it acknowledges and then serves the master one byte at a time.

Every byte is handed to software under clock stretching. A byte written by the master is latched into the data register, and SCL is held low until software reads that register. Only then is the byte acknowledged. When the master reads, SCL is held low until software writes the next byte into the data register. A status flag marks the first byte received after the address.

Start, stop and data events set raw interrupt bits. Each raw bit has a mask bit and a write-one-to-clear bit, and a single interrupt output combines the unmasked bits. The pins are active-high pull-down enables (`sclLowOut`, `sdaLowOut`), which the pad turns into open-drain drivers.

Top module: `iic_target`

## Requirements
- R1: The own address is bits [6:0] of register 0. After a START, the target compares bits [7:1] of the first byte with the own address (bit 0 = 1 means the master reads). On a match it pulls SDA low through the ninth clock. On a mismatch it never pulls SDA low and records no data event until the next START or STOP.
- R2: The register map is: 0 own address, 1 control, 2 status (read only), 3 data, 4 interrupt mask, 5 raw interrupts (read only), 6 masked interrupts (read only), 7 interrupt clear (write only). In the status register, bit 0 is receive pending, bit 1 is transmit pending and bit 2 is first byte. All registers reset to zero.
- R3: After the eighth bit of a byte written by the master, the byte goes into the data register, receive pending is set, and SCL is held low. Reading register 3 clears receive pending. The target then releases SCL and acknowledges the byte.
- R4: When addressed for a read, the target sets transmit pending and holds SCL low after the address acknowledge. A write to register 3 clears transmit pending, puts that byte on SDA most significant bit first, and releases SCL.
- R5: The first-byte flag is set together with receive pending only for the first data byte after the own address. It is cleared by a read of register 3, and it stays 0 throughout a read transfer.
- R6: Raw interrupt bits are data (bit 0), start (bit 1) and stop (bit 2). Register 6 reads raw AND mask. Writing 1 to a bit of register 7 clears that raw bit. The interrupt output is high when any masked bit is set.
- R7: Bit 0 of register 1 enables the target. While it is 0 the target never drives SCL or SDA and records no event.
- R8: The data register keeps its value until software writes it or the master writes a new byte to the target.
- R9: START is SDA falling while SCL is high, and it sets the start bit. STOP is SDA rising while SCL is high: it sets the stop bit and returns the target to idle with both lines released.
- R10: When the master does not acknowledge a byte it read, the target releases SDA, leaves transmit pending clear and waits for the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclLowOut | output | 1 | 1 pulls SCL low (stretch) |
| sdaLowOut | output | 1 | 1 pulls SDA low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects on data register) |
| regAddr | input | 3 | Register index |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
If the byte state machine goes wrong, the master sees it at the pins within one bit time. A missing stretch lets SCL rise before software has served the byte. A missed shift shows up as a wrong bit or a wrong acknowledge level in the ninth clock. Pending and first-byte flags that disagree with the bus are exposed by the next status read. That read comes within a few cycles of the eighth falling edge, because the master waits on the stretched clock. Interrupt bits that are set or cleared wrongly show up on `irqOut` in the cycle after the event or after the clear write.

// File: rtl/iic_target_pkg.sv
package iic_target_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_OWN    = 3'd0;
  localparam logic [REG_AW-1:0] REG_CTRL   = 3'd1;
  localparam logic [REG_AW-1:0] REG_STAT   = 3'd2;
  localparam logic [REG_AW-1:0] REG_DATA   = 3'd3;
  localparam logic [REG_AW-1:0] REG_MASK   = 3'd4;
  localparam logic [REG_AW-1:0] REG_RAW    = 3'd5;
  localparam logic [REG_AW-1:0] REG_MASKED = 3'd6;
  localparam logic [REG_AW-1:0] REG_CLEAR  = 3'd7;

  localparam int IRQ_DATA  = 0;
  localparam int IRQ_START = 1;
  localparam int IRQ_STOP  = 2;
  localparam int IRQ_N     = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX_BYTE,
    ST_RX_HOLD,
    ST_RX_ACK,
    ST_TX_HOLD,
    ST_TX_SETUP,
    ST_TX_BYTE,
    ST_TX_ACK
  } tgtState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic latchRx;
    logic firstMark;
    logic reqTx;
    logic dropTx;
    logic evStart;
    logic evStop;
    logic evData;
  } dpStrobe_t;

endpackage

// File: rtl/iic_pin_sync.sv
module iic_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '1;
        else       q <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '1;
        else       q <= g_stage[s-1].q;
      end
    end
  end

  assign pinSync = g_stage[STAGES-1].q;

endmodule

// File: rtl/iic_target_ctrl.sv
module iic_target_ctrl
  import iic_target_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 7,
  parameter int SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              enable,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              rxReq,
  input  logic              txReq,
  input  logic [DATA_W-1:0] shiftReg,
  output dpStrobe_t         stb,
  output logic              sclLow,
  output logic              sdaLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam int SET_W = $clog2(SETUP_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETUP_CYC - 1);

  tgtState_e state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic [SET_W-1:0] setupCnt;
  logic sclPrev, sdaPrev;
  logic rwBit, firstPend, masterAck;
  logic cntInc, setFirst;

  // Edge and condition detection on synchronised lines
  logic sclRise, sclFall, startDet, stopDet, addrMatch;
  assign sclRise   = !sclPrev && sclS;
  assign sclFall   = sclPrev && !sclS;
  assign startDet  = sclPrev && sclS && sdaPrev && !sdaS;
  assign stopDet   = sclPrev && sclS && !sdaPrev && sdaS;
  assign addrMatch = (shiftReg[DATA_W-1 -: ADDR_W] == ownAddr);

  always_comb begin
    nextState = state;
    stb       = '0;
    cntInc    = 1'b0;
    setFirst  = 1'b0;
    if (!enable) begin
      nextState = ST_IDLE;
    end else if (startDet) begin
      nextState   = ST_ADDR;
      stb.evStart = 1'b1;
    end else if (stopDet) begin
      nextState  = ST_IDLE;
      stb.evStop = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise && bitCnt != CNT_FULL) begin
            stb.shiftIn = 1'b1;
            cntInc      = 1'b1;
          end
          if (sclFall && bitCnt == CNT_FULL)
            nextState = addrMatch ? ST_ADDR_ACK : ST_IDLE;
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rwBit) begin
              nextState  = ST_TX_HOLD;
              stb.reqTx  = 1'b1;
              stb.evData = 1'b1;
            end else begin
              nextState = ST_RX_BYTE;
              setFirst  = 1'b1;
            end
          end
        end
        ST_RX_BYTE: begin
          if (sclRise && bitCnt != CNT_FULL) begin
            stb.shiftIn = 1'b1;
            cntInc      = 1'b1;
          end
          if (sclFall && bitCnt == CNT_FULL) begin
            nextState     = ST_RX_HOLD;
            stb.latchRx   = 1'b1;
            stb.firstMark = firstPend;
            stb.evData    = 1'b1;
          end
        end
        ST_RX_HOLD: if (!rxReq) nextState = ST_RX_ACK;
        ST_RX_ACK:  if (sclFall) nextState = ST_RX_BYTE;
        ST_TX_HOLD: begin
          if (!txReq) begin
            nextState  = ST_TX_SETUP;
            stb.loadTx = 1'b1;
          end
        end
        ST_TX_SETUP: if (setupCnt == SET_LAST) nextState = ST_TX_BYTE;
        ST_TX_BYTE: begin
          if (sclFall) begin
            stb.shiftOut = 1'b1;
            cntInc       = 1'b1;
            if (bitCnt == CNT_LAST) nextState = ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (sclFall) begin
            if (masterAck) begin
              nextState  = ST_TX_HOLD;
              stb.reqTx  = 1'b1;
              stb.evData = 1'b1;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
    stb.dropTx = (state == ST_TX_HOLD) && (nextState != ST_TX_HOLD) && !stb.loadTx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      setupCnt  <= '0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      rwBit     <= 1'b0;
      firstPend <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state   <= nextState;
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (nextState != state || stb.evStart) bitCnt <= '0;
      else if (cntInc)                       bitCnt <= bitCnt + 1'b1;
      if (state == ST_TX_SETUP) setupCnt <= setupCnt + 1'b1;
      else                      setupCnt <= '0;
      if (state == ST_ADDR && nextState == ST_ADDR_ACK) rwBit <= shiftReg[0];
      if (stb.evStart || stb.latchRx) firstPend <= 1'b0;
      else if (setFirst)              firstPend <= 1'b1;
      if (state == ST_TX_ACK && sclRise) masterAck <= !sdaS;
    end
  end

  always_comb begin
    sclLow = (state == ST_RX_HOLD) || (state == ST_TX_HOLD) || (state == ST_TX_SETUP);
    sdaLow = (state == ST_ADDR_ACK) || (state == ST_RX_HOLD) || (state == ST_RX_ACK) ||
             (((state == ST_TX_SETUP) || (state == ST_TX_BYTE)) && !shiftReg[DATA_W-1]);
  end

  // R1: a rejected address never produces an acknowledge
  a_r1_no_ack_on_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_ADDR && sclFall && bitCnt == CNT_FULL && !addrMatch &&
     !startDet && !stopDet) |=> !sdaLow);

  // R7: a disabled target leaves both lines alone
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && $past(!enable)) |-> (!sclLow && !sdaLow));

  // R9: a STOP always frees both lines on the next cycle
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    (enable && stopDet && !startDet) |=> (!sclLow && !sdaLow));

endmodule

// File: rtl/iic_target_dp.sv
module iic_target_dp
  import iic_target_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaS,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] shiftReg,
  output logic [ADDR_W-1:0] ownAddr,
  output logic              enable,
  output logic              rxReq,
  output logic              txReq,
  output logic              irq
);

  localparam int PAD_ADDR = DATA_W - ADDR_W;
  localparam int PAD_IRQ  = DATA_W - IRQ_N;

  logic [DATA_W-1:0] dataReg;
  logic [IRQ_N-1:0]  irqMask, irqRaw, irqEvent;
  logic firstByte;
  logic wrOwn, wrCtrl, wrData, wrMask, wrClear, rdData;

  assign wrOwn   = regWrEn && regAddr == REG_OWN;
  assign wrCtrl  = regWrEn && regAddr == REG_CTRL;
  assign wrData  = regWrEn && regAddr == REG_DATA;
  assign wrMask  = regWrEn && regAddr == REG_MASK;
  assign wrClear = regWrEn && regAddr == REG_CLEAR;
  assign rdData  = regRdEn && regAddr == REG_DATA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= '0;
      enable  <= 1'b0;
      irqMask <= '0;
    end else begin
      if (wrOwn)  ownAddr <= regWdata[ADDR_W-1:0];
      if (wrCtrl) enable  <= regWdata[0];
      if (wrMask) irqMask <= regWdata[IRQ_N-1:0];
    end
  end

  // Shift register and shared data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
    end else begin
      if (stb.loadTx)        shiftReg <= dataReg;
      else if (stb.shiftIn)  shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      else if (stb.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      if (stb.latchRx)   dataReg <= shiftReg;
      else if (wrData)   dataReg <= regWdata;
    end
  end

  // Service request flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReq     <= 1'b0;
      firstByte <= 1'b0;
      txReq     <= 1'b0;
    end else begin
      if (stb.latchRx) begin
        rxReq     <= 1'b1;
        firstByte <= stb.firstMark;
      end else if (rdData) begin
        rxReq     <= 1'b0;
        firstByte <= 1'b0;
      end
      if (stb.reqTx)                  txReq <= 1'b1;
      else if (stb.dropTx || wrData)  txReq <= 1'b0;
    end
  end

  // Interrupt bit slices
  always_comb begin
    irqEvent            = '0;
    irqEvent[IRQ_DATA]  = stb.evData;
    irqEvent[IRQ_START] = stb.evStart;
    irqEvent[IRQ_STOP]  = stb.evStop;
  end

  for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         irqRaw[k] <= 1'b0;
      else if (irqEvent[k])              irqRaw[k] <= 1'b1;
      else if (wrClear && regWdata[k])   irqRaw[k] <= 1'b0;
    end
  end

  assign irq = |(irqRaw & irqMask);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      REG_OWN:    regRdata = {{PAD_ADDR{1'b0}}, ownAddr};
      REG_CTRL:   regRdata = {{(DATA_W-1){1'b0}}, enable};
      REG_STAT:   regRdata = {{(DATA_W-3){1'b0}}, firstByte, txReq, rxReq};
      REG_DATA:   regRdata = dataReg;
      REG_MASK:   regRdata = {{PAD_IRQ{1'b0}}, irqMask};
      REG_RAW:    regRdata = {{PAD_IRQ{1'b0}}, irqRaw};
      REG_MASKED: regRdata = {{PAD_IRQ{1'b0}}, irqRaw & irqMask};
      default:    regRdata = '0;
    endcase
  end

  // R3: a data read with no new byte arriving leaves receive pending clear
  a_r3_read_clears_rx: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !stb.latchRx) |=> !rxReq);

  // R5: the first-byte flag is never set without receive pending
  a_r5_first_needs_rx: assert property (@(posedge clk) disable iff (!rstN)
    firstByte |-> rxReq);

  // R6: a clear write with no new data event removes the data bit
  a_r6_clear_data: assert property (@(posedge clk) disable iff (!rstN)
    (wrClear && regWdata[IRQ_DATA] && !stb.evData) |=> !irqRaw[IRQ_DATA]);

endmodule

// File: rtl/iic_target.sv
module iic_target
  import iic_target_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclLowOut,
  output logic              sdaLowOut,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  logic [1:0] pinSync;
  logic sclS, sdaS;
  dpStrobe_t stb;
  logic [DATA_W-1:0] shiftReg;
  logic [ADDR_W-1:0] ownAddr;
  logic enable, rxReq, txReq;

  iic_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .pinIn({sclIn, sdaIn}), .pinSync(pinSync)
  );
  assign sclS = pinSync[1];
  assign sdaS = pinSync[0];

  iic_target_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .enable(enable),
    .ownAddr(ownAddr), .rxReq(rxReq), .txReq(txReq), .shiftReg(shiftReg),
    .stb(stb), .sclLow(sclLowOut), .sdaLow(sdaLowOut)
  );

  iic_target_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaS(sdaS),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .shiftReg(shiftReg), .ownAddr(ownAddr), .enable(enable),
    .rxReq(rxReq), .txReq(txReq), .irq(irqOut)
  );

  // R3: a new receive request always comes with SCL held
  a_r3_stretch_on_rx: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReq) |-> sclLowOut);

  // R4: a new transmit request always comes with SCL held
  a_r4_stretch_on_tx: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> sclLowOut);

endmodule

// File: tb/test_iic_target.sv
module test_iic_target;
  import iic_target_pkg::*;

  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic mSclLow, mSdaLow;
  logic sclLowOut, sdaLowOut, irqOut;
  logic sclLine, sdaLine;
  logic regWrEn, regRdEn;
  logic [2:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] lastData;
  int checks = 0;
  int fails = 0;

  assign sclLine = !(mSclLow || sclLowOut);
  assign sdaLine = !(mSdaLow || sdaLowOut);

  iic_target i_iic_target (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclLowOut(sclLowOut), .sdaLowOut(sdaLowOut),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [7:0] expMasked(input logic [7:0] raw, input logic [7:0] mask);
    return raw & mask & 8'h07;
  endfunction
  function automatic logic [7:0] expStatus(input bit rx, input bit tx, input bit first);
    return {5'd0, first, tx, rx};
  endfunction
  function automatic bit expAckLevel(input logic [7:0] addrByte, input logic [6:0] own, input bit en);
    return !(en && addrByte[7:1] == own);
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic mStart();
    mSdaLow = 1'b0; mSclLow = 1'b0; waitCyc(2*Q);
    mSdaLow = 1'b1; waitCyc(Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic mStop();
    mSdaLow = 1'b1; waitCyc(Q);
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitCyc(Q);
    mSdaLow = 1'b0; waitCyc(2*Q);
  endtask

  task automatic mWriteBit(input bit b);
    mSdaLow = !b; waitCyc(Q);
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitCyc(2*Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic mReadBit(output bit b);
    mSdaLow = 1'b0; waitCyc(Q);
    mSclLow = 1'b0;
    while (!sclLine) @(negedge clk);
    waitCyc(Q);
    b = sdaLine;
    waitCyc(Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic mSendBits(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) mWriteBit(v[i]);
  endtask

  // Master writes nBytes; expectAck selects addressed or ignored behaviour
  task automatic writeXfer(input logic [6:0] target, input int nBytes, input bit expectAck);
    bit ackBit;
    logic [7:0] v, rd;
    mStart();
    regRead(REG_RAW, rd);
    checkEq("R9 start bit set", rd[1], 1);
    mSendBits({target, 1'b0});
    mReadBit(ackBit);
    checkEq("R1 address ack level", ackBit, expectAck ? 0 : 1);
    for (int i = 0; i < nBytes; i++) begin
      v = 8'($urandom);
      mSendBits(v);
      if (expectAck) begin
        mSclLow = 1'b0;
        waitCyc(12);
        checkEq("R3 SCL held for receive", sclLine, 0);
        regRead(REG_STAT, rd);
        checkEq("R3 receive pending", rd[0], 1);
        checkEq("R5 first-byte flag", rd[2], (i == 0) ? 1 : 0);
        checkEq("R2 status word", rd, expStatus(1, 0, i == 0));
        regRead(REG_RAW, rd);
        checkEq("R6 data raw bit", rd[0], 1);
        regRead(REG_DATA, rd);
        checkEq("R8 received byte in data register", rd, v);
        regRead(REG_STAT, rd);
        checkEq("R5 flags cleared by data read", rd, 0);
        mReadBit(ackBit);
        checkEq("R3 ack after service", ackBit, 0);
        lastData = v;
      end else begin
        checkEq("R7 no stretch when ignored", sclLowOut, 0);
        mReadBit(ackBit);
        checkEq("R1 ignored byte not acked", ackBit, 1);
      end
    end
    mStop();
    regRead(REG_RAW, rd);
    checkEq("R9 stop bit set", rd[2], expectAck ? 1 : rd[2]);
    checkEq("R9 lines released", {sclLowOut, sdaLowOut}, 0);
  endtask

  task automatic readXfer(input logic [6:0] target, input int nBytes);
    bit ackBit, b;
    logic [7:0] v, got, rd;
    mStart();
    mSendBits({target, 1'b1});
    mReadBit(ackBit);
    checkEq("R1 read address ack", ackBit, 0);
    for (int i = 0; i < nBytes; i++) begin
      mSclLow = 1'b0;
      waitCyc(12);
      checkEq("R4 SCL held for transmit", sclLine, 0);
      regRead(REG_STAT, rd);
      checkEq("R4 transmit pending", rd[1], 1);
      checkEq("R5 first flag zero in read", rd[2], 0);
      v = 8'($urandom);
      regWrite(REG_DATA, v);
      waitCyc(2);
      regRead(REG_STAT, rd);
      checkEq("R4 write clears transmit pending", rd[1], 0);
      got = '0;
      for (int k = 7; k >= 0; k--) begin
        mReadBit(b);
        got[k] = b;
      end
      checkEq("R4 byte on SDA msb first", got, v);
      lastData = v;
      mWriteBit(i == nBytes - 1);
      if (i == nBytes - 1) begin
        waitCyc(6);
        regRead(REG_STAT, rd);
        checkEq("R10 no transmit pending after nack", rd[1], 0);
        checkEq("R10 lines released after nack", {sclLowOut, sdaLowOut}, 0);
      end
    end
    mStop();
    regRead(REG_DATA, rd);
    checkEq("R8 data register keeps written byte", rd, lastData);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] rd, m, c;
    logic [6:0] own, other;
    void'($urandom(32'h5EED_1C2A));
    rstN = 1'b0; mSclLow = 1'b0; mSdaLow = 1'b0;
    regWrEn = 1'b0; regRdEn = 1'b0; regAddr = '0; regWdata = '0;
    lastData = '0;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);

    // Reset state
    regRead(REG_STAT, rd);  checkEq("R2 status reset", rd, 0);
    regRead(REG_RAW, rd);   checkEq("R6 raw reset", rd, 0);
    regRead(REG_DATA, rd);  checkEq("R8 data reset", rd, 0);
    regRead(REG_CTRL, rd);  checkEq("R7 disabled at reset", rd, 0);
    checkEq("R6 irq low at reset", irqOut, 0);
    checkEq("R7 lines free at reset", {sclLowOut, sdaLowOut}, 0);

    own = 7'h3A;
    regWrite(REG_OWN, {1'b1, own});
    regRead(REG_OWN, rd);
    checkEq("R1 own address field", rd, {1'b0, own});
    regWrite(REG_CTRL, 8'h01);
    regWrite(REG_MASK, 8'h07);

    // Directed write then read
    writeXfer(own, 3, 1'b1);
    regRead(REG_RAW, rd);
    checkEq("R6 all raw bits after write", rd, 8'h07);
    checkEq("R6 irq follows masked", irqOut, 1);

    // Mask and clear patterns
    for (int i = 0; i < 6; i++) begin
      m = 8'($urandom) & 8'h07;
      regWrite(REG_MASK, m);
      regRead(REG_MASKED, rd);
      checkEq("R6 masked read", rd, expMasked(8'h07, m));
      checkEq("R6 irq is OR of masked", irqOut, |expMasked(8'h07, m));
    end
    c = 8'h05;
    regWrite(REG_CLEAR, c);
    regRead(REG_RAW, rd);
    checkEq("R6 partial clear", rd, 8'h07 & ~c);
    regWrite(REG_CLEAR, 8'h07);
    regRead(REG_RAW, rd);
    checkEq("R6 full clear", rd, 0);
    regWrite(REG_MASK, 8'h07);
    checkEq("R6 irq low after clear", irqOut, 0);

    readXfer(own, 2);
    regWrite(REG_CLEAR, 8'h07);

    // Address mismatch: no data event, data register untouched
    other = own ^ 7'h11;
    writeXfer(other, 1, 1'b0);
    regRead(REG_RAW, rd);
    checkEq("R1 mismatch leaves only start and stop", rd, 8'h06);
    regRead(REG_DATA, rd);
    checkEq("R8 data kept across ignored transfer", rd, lastData);
    regWrite(REG_CLEAR, 8'h07);

    // Disabled target
    regWrite(REG_CTRL, 8'h00);
    mStart();
    mSendBits({own, 1'b0});
    begin
      bit ackBit;
      mReadBit(ackBit);
      checkEq("R7 disabled gives no ack", ackBit, expAckLevel({own, 1'b0}, own, 1'b0));
    end
    mStop();
    regRead(REG_RAW, rd);
    checkEq("R7 disabled records no event", rd, 0);
    regWrite(REG_CTRL, 8'h01);

    // Software write outside a transfer updates the data register
    regWrite(REG_DATA, 8'hC3);
    regRead(REG_DATA, rd);
    checkEq("R8 software write visible", rd, 8'hC3);
    lastData = 8'hC3;

    // Random transfers
    for (int it = 0; it < 6; it++) begin
      own = 7'($urandom);
      regWrite(REG_OWN, {1'b0, own});
      if ($urandom % 2 == 0) writeXfer(own, 1 + int'($urandom % 3), 1'b1);
      else                   readXfer(own, 1 + int'($urandom % 3));
      regWrite(REG_CLEAR, 8'h07);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule